// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block carries 9-bit words from a producer running on a write clock to a consumer running on an unrelated read clock. Storage depth is a power-of-two parameter. The block reports four status flags. Empty and almost-empty are registered on the read clock. Full and almost-full are registered on the write clock. Each pointer crosses to the other side as a Gray code through a two-stage synchronizer. Because of this, a flag on the far side can release late but never early.

The almost thresholds are offsets of any single word. The almost-empty offset counts up from zero words. The almost-full offset counts down from a full FIFO. Both return to 7 on reset. The offsets are loaded through a small port on the write clock. A load takes effect only while the FIFO is idle, which means no write is requested and the write side sees no stored words.

Read data is registered on the read clock. An output-enable input decides whether the word reaches the data pins. A separate drive output shows when the pins would be driven rather than floating.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: Words leave in the order they were written, 9 bits intact. A read accepted at a read-clock edge presents the oldest stored word on the registered output after that edge.
- R2: The empty flag changes only on read-clock edges. After a write into an empty FIFO, empty is still asserted after the first read-clock edge that follows the write, and it clears once the pointer has crossed.
- R3: The full flag is registered on the write clock. It asserts at the write-clock edge of the write that makes the level equal DEPTH. It clears only after reads bring the level below DEPTH.
- R4: A write request while full is ignored. Nothing is stored and the write pointer does not move.
- R5: A read request while empty is ignored. The read pointer holds and the registered output keeps its last value.
- R6: Almost-empty is asserted when the read side sees a level less than or equal to the almost-empty offset.
- R7: Almost-full is asserted when the write side sees a level of at least DEPTH minus the almost-full offset.
- R8: A pulse on the load enable writes the load value into the almost-empty offset when select is 0, and into the almost-full offset when select is 1. The load is taken only when write enable is low and the write side sees the FIFO as empty. Otherwise it is ignored.
- R9: While reset is low (synchronous, active low, held across edges of both clocks), the FIFO is emptied. After reset, empty and almost-empty are 1, full and almost-full are 0, the read output register is 0, and both offsets are 7.
- R10: While output enable is high, the drive output is 1 and the data output shows the read register. While output enable is low, the drive output is 0 and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| wclk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| ld_en | input | 1 | Offset load strobe (write clock) |
| ld_sel | input | 1 | 0 = almost-empty offset, 1 = almost-full offset |
| ld_val | input | AW | Offset value to load |
| full | output | 1 | FIFO full (write clock) |
| afull | output | 1 | Almost full (write clock) |
| rclk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| oe | input | 1 | Output enable |
| rd_data | output | 9 | Registered read word, 0 when not enabled |
| rd_drive | output | 1 | High when the data output would be driven |
| empty | output | 1 | FIFO empty (read clock) |
| aempty | output | 1 | Almost empty (read clock) |

## Verification
The main function is exercised with a table of cumulative write and read bursts. The table steps the level through three words, eight words, nine words, full, overfilled, seven words, empty and overdrained. These points sit on each side of both default thresholds, so each flag is shown to change at its own boundary and not one word off. The overfill and overdrain steps, followed by ordered read-back, show whether a rejected request still corrupted storage or moved a pointer. Directed cases cover the following:
- the edge timing of empty release and full assertion;
- loads while idle compared with loads while busy;
- restoration of the defaults by reset;
- output-enable gating.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the dual-clock flag FIFO.
// Assumes nothing beyond IEEE 1800-2017.
package dcf_pkg;
    // Number of flops used for each pointer crossing.
    localparam int SYNC_STAGES = 2;
    // Which offset register the load port addresses.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchronizer for a Gray-coded bus.
// Assumes the input changes by at most one bit per source clock.
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stg
        if (k == 0) begin : g_first
            // Capture the foreign-domain value.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= d;
            end
        end else begin : g_next
            // Shift through the remaining stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
// Module: write-side pointer, full / almost-full flags and offset registers.
// Assumes rgray_s is the read pointer already synchronized into wclk.
// Offsets are only loaded while idle, so the read side may sample them directly.
module dcf_wr_ctrl #(
    parameter int DEPTH   = 16,
    parameter int AW      = 4,
    parameter int DEF_OFS = 7
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    input  logic          ld_en,
    input  logic          ld_sel,
    input  logic [AW-1:0] ld_val,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs
);
    localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] OFS_RST  = AW'(DEF_OFS);

    logic [AW:0] rbin_s, wbin_nx, lvl_nx;
    logic        winc, idle;

    // Gray-to-binary conversion of the crossed read pointer.
    always_comb begin
        for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign winc    = wr_en && !full;
    assign wbin_nx = wbin + {{AW{1'b0}}, winc};
    assign lvl_nx  = wbin_nx - rbin_s;
    assign idle    = !wr_en && (wbin == rbin_s);

    // Pointer advance and flag registration on the write clock.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            afull <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
            full  <= (lvl_nx == FULL_LVL);
            afull <= (lvl_nx >= (FULL_LVL - {1'b0, af_ofs}));
        end
    end

    // Offset registers, loadable only while idle.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_ofs <= OFS_RST;
            af_ofs <= OFS_RST;
        end else if (ld_en && idle) begin
            if (ld_sel == dcf_pkg::SEL_AF) af_ofs <= ld_val;
            else                           ae_ofs <= ld_val;
        end
    end

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wbin)); // R4
    AST_FULL_WITHIN_AFULL: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> afull); // R7
    AST_WR_LEVEL_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
        ((wbin - rbin_s) <= FULL_LVL)); // R3
    AST_BUSY_LOAD_IGNORED: assert property (@(posedge wclk) disable iff (!rst_n)
        (ld_en && !idle) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R8
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
// Module: read-side pointer and empty / almost-empty flags.
// Assumes wgray_s is the write pointer already synchronized into rclk,
// and that ae_ofs is quasi-static (changes only while the FIFO is idle).
module dcf_rd_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_ofs,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          aempty
);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [AW:0] wbin_s, rbin_nx, lvl_nx;
    logic        rinc;

    // Gray-to-binary conversion of the crossed write pointer.
    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign rinc    = rd_en && !empty;
    assign rbin_nx = rbin + {{AW{1'b0}}, rinc};
    assign lvl_nx  = wbin_s - rbin_nx;

    // Pointer advance and flag registration on the read clock.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            empty  <= 1'b1;
            aempty <= 1'b1;
        end else begin
            rbin   <= rbin_nx;
            rgray  <= rbin_nx ^ (rbin_nx >> 1);
            empty  <= (lvl_nx == '0);
            aempty <= (lvl_nx <= {1'b0, ae_ofs});
        end
    end

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rbin)); // R5
    AST_EMPTY_WITHIN_AEMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> aempty); // R6
    AST_RD_LEVEL_BOUND: assert property (@(posedge rclk) disable iff (!rst_n)
        ((wbin_s - rbin) <= FULL_LVL)); // R1
endmodule

// File: rtl/dual_clock_flag_fifo.sv
`timescale 1ns/1ps
// Module: top of the dual-clock FIFO with programmable almost flags.
// Holds the storage array and the registered read word; pointer logic and
// flags live in the write and read controllers. Assumes DEPTH is a power
// of two larger than DEF_OFS and that rst_n is held over edges of both clocks.
module dual_clock_flag_fifo #(
    parameter int DEPTH   = 16,
    parameter int WIDTH   = 9,
    parameter int DEF_OFS = 7,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [AW-1:0]    ld_val,
    output logic             full,
    output logic             afull,
    input  logic             rclk,
    input  logic             rd_en,
    input  logic             oe,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drive,
    output logic             empty,
    output logic             aempty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] q;
    logic [AW:0]      wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic [AW-1:0]    ae_ofs, af_ofs;

    dcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .wbin(wbin), .wgray(wgray), .full(full), .afull(afull),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
        .ae_ofs(ae_ofs), .rbin(rbin), .rgray(rgray),
        .empty(empty), .aempty(aempty)
    );

    dcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    // Storage write on accepted requests.
    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Registered read word, loaded on accepted reads.
    always_ff @(posedge rclk) begin
        if (!rst_n)                q <= '0;
        else if (rd_en && !empty)  q <= mem[rbin[AW-1:0]];
    end

    // Output-enable gating in place of a floating bus.
    assign rd_drive = oe;
    assign rd_data  = oe ? q : '0;

    AST_RESET_FLAGS: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && aempty)); // R9
endmodule

// File: tb/dual_clock_flag_fifo_test.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo_test;
    localparam int DEPTH = 16;
    localparam int W     = 9;
    localparam int AW    = 4;

    logic rst_n = 1'b0, wclk = 1'b0, rclk = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, oe = 1'b1;
    logic ld_en = 1'b0, ld_sel = 1'b0;
    logic [AW-1:0] ld_val = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic rd_drive, empty, aempty, full, afull;

    always #4   wclk = ~wclk;
    always #5.5 rclk = ~rclk;

    dual_clock_flag_fifo #(.DEPTH(DEPTH), .WIDTH(W), .DEF_OFS(7)) uut (
        .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .full(full), .afull(afull), .rclk(rclk), .rd_en(rd_en), .oe(oe),
        .rd_data(rd_data), .rd_drive(rd_drive), .empty(empty), .aempty(aempty)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [W-1:0] sb [DEPTH];
    int head = 0, tail = 0, mcnt = 0;
    logic [W-1:0] last_rd = '0;
    logic [W-1:0] pat = 9'h0A5;

    // {writes[7:0], reads[7:0], empty, aempty, full, afull}
    localparam logic [19:0] VEC [8] = '{
        {8'd3, 8'd0, 4'b0100},
        {8'd5, 8'd0, 4'b0000},
        {8'd1, 8'd0, 4'b0001},
        {8'd7, 8'd0, 4'b0011},
        {8'd2, 8'd0, 4'b0011},
        {8'd0, 8'd9, 4'b0100},
        {8'd0, 8'd7, 4'b1100},
        {8'd0, 8'd2, 4'b1100}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge wclk) rst_n = 1'b0;
        repeat (4) @(negedge rclk);
        repeat (2) @(negedge wclk);
        rst_n = 1'b1;
        head = 0; tail = 0; mcnt = 0; last_rd = '0;
    endtask

    task automatic wr_word();
        @(negedge wclk);
        wr_en = 1'b1; wr_data = pat;
        @(negedge wclk);
        wr_en = 1'b0;
        if (mcnt < DEPTH) begin
            sb[tail] = pat; tail = (tail + 1) % DEPTH; mcnt++;
        end
        pat = pat + 9'd37;
    endtask

    task automatic rd_word(input string req);
        logic [W-1:0] exp;
        @(negedge rclk) rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
        if (mcnt > 0) begin
            exp = sb[head]; head = (head + 1) % DEPTH; mcnt--;
        end else begin
            exp = last_rd;
        end
        last_rd = exp;
        chk(rd_data == exp, req, "read word", int'(rd_data), int'(exp));
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic chk_flags(input logic [3:0] exp, input string req);
        chk({empty, aempty, full, afull} == exp, req, "flags {e,ae,f,af}",
            int'({empty, aempty, full, afull}), int'(exp));
    endtask

    task automatic load(input logic sel, input logic [AW-1:0] v);
        @(negedge wclk);
        ld_en = 1'b1; ld_sel = sel; ld_val = v;
        @(negedge wclk);
        ld_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge rclk);
        // R9: reset state
        chk_flags(4'b1100, "R9");
        chk(rd_data == '0, "R9", "read register after reset", int'(rd_data), 0);

        // Table walk: R1 R3 R4 R5 R6 R7
        foreach (VEC[i]) begin
            for (int k = 0; k < int'(VEC[i][19:12]); k++) wr_word();
            settle();
            for (int k = 0; k < int'(VEC[i][11:4]); k++) rd_word("R1/R4/R5");
            settle();
            chk_flags(VEC[i][3:0], "R6/R7/R3");
        end

        // R2: empty release is delayed by the crossing
        @(negedge wclk) begin wr_en = 1'b1; wr_data = pat; end
        @(posedge wclk);
        #1 wr_en = 1'b0;
        sb[tail] = pat; tail = (tail + 1) % DEPTH; mcnt++; pat = pat + 9'd37;
        @(posedge rclk);
        #1 chk(empty == 1'b1, "R2", "empty one edge after write", int'(empty), 1);
        settle();
        chk(empty == 1'b0, "R2", "empty after crossing", int'(empty), 0);
        rd_word("R1");
        settle();

        // R3: full asserts on the filling write edge
        for (int k = 0; k < DEPTH - 1; k++) wr_word();
        settle();
        chk(full == 1'b0, "R3", "full at DEPTH-1", int'(full), 0);
        @(negedge wclk) begin wr_en = 1'b1; wr_data = pat; end
        @(negedge wclk) wr_en = 1'b0;
        sb[tail] = pat; tail = (tail + 1) % DEPTH; mcnt++; pat = pat + 9'd37;
        chk(full == 1'b1, "R3", "full right after filling write", int'(full), 1);
        rd_word("R1");
        settle();
        chk(full == 1'b0, "R3", "full after one read", int'(full), 0);

        // R10: output enable gating
        @(negedge rclk) oe = 1'b0;
        #1 chk(rd_drive == 1'b0 && rd_data == '0, "R10", "disabled output",
               int'({rd_drive, rd_data}), 0);
        @(negedge rclk) oe = 1'b1;
        #1 chk(rd_drive == 1'b1 && rd_data == last_rd, "R10", "enabled output",
               int'(rd_data), int'(last_rd));

        // R9: reset mid-stream empties, then read is ignored (R5)
        do_reset();
        settle();
        chk_flags(4'b1100, "R9");
        rd_word("R5");

        // R8: offset loading
        load(1'b0, 4'd3);
        load(1'b1, 4'd2);
        for (int k = 0; k < 3; k++) wr_word();
        settle();
        chk(aempty == 1'b1, "R8", "aempty at 3 with offset 3", int'(aempty), 1);
        wr_word();
        settle();
        chk(aempty == 1'b0, "R8", "aempty at 4 with offset 3", int'(aempty), 0);
        load(1'b0, 4'd10);
        settle();
        chk(aempty == 1'b0, "R8", "busy load ignored", int'(aempty), 0);
        for (int k = 0; k < 9; k++) wr_word();
        settle();
        chk(afull == 1'b0, "R8", "afull at 13 with offset 2", int'(afull), 0);
        wr_word();
        settle();
        chk(afull == 1'b1, "R8", "afull at 14 with offset 2", int'(afull), 1);

        // R9: defaults restored by reset
        do_reset();
        for (int k = 0; k < 4; k++) wr_word();
        settle();
        chk(aempty == 1'b1 && afull == 1'b0, "R9", "default offsets at 4",
            int'({aempty, afull}), 2);
        for (int k = 0; k < 5; k++) wr_word();
        settle();
        chk(aempty == 1'b0 && afull == 1'b1, "R9", "default offsets at 9",
            int'({aempty, afull}), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule